// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Unit with Result Register

This block computes one of sixteen operation kinds on two WIDTH-bit operands in a single combinational pass. A four-bit select and a carry input choose the operation. The result is shown on a combinational output, and a register captures it on a rising clock edge while the load enable is high.

All arithmetic goes through one adder. Its second operand is steered to B, the complement of B, all zeros or all ones. With the carry input added in, that one adder gives addition, add-with-carry, subtraction, subtract-with-borrow, increment, decrement and pass-through of A. A bitwise logic section and one-bit left and right shifts share the output multiplexer. The shifts take their fill bit from a serial input, which the user ties low for a zero fill.

A decoder turns the select and carry input into a small set of steering strobes. The datapath acts on those strobes only. The select is `sel[3:0]`, where `sel[3:2]` picks the section and `sel[1:0]` picks the variant.

Top module: `alsu_core`

## Requirements
- R1: With `sel` = 4'b0000, `result` = opA + opB + carryIn, modulo 2^WIDTH.
- R2: With `sel` = 4'b0001, `result` = opA + ~opB + carryIn, modulo 2^WIDTH. With carryIn = 0 this is subtract-with-borrow; with carryIn = 1 it is two's-complement subtraction.
- R3: With `sel` = 4'b0010, `result` = opA + carryIn. This is a transfer of A when carryIn = 0 and an increment when carryIn = 1.
- R4: With `sel` = 4'b0011, `result` = opA + all-ones + carryIn. This is a decrement when carryIn = 0 and a transfer of A when carryIn = 1.
- R5: When `sel[3:2]` = 2'b00, `carryOut` is bit WIDTH of the full adder sum of opA, the steered operand and carryIn.
- R6: When `sel[3:2]` = 2'b01, `sel[1:0]` picks the bitwise function: 00 AND, 01 OR, 10 XOR, 11 NOT opA. carryIn has no effect, and `carryOut` is 0.
- R7: When `sel[3:2]` = 2'b10, `result` = {serialIn, opA[WIDTH-1:1]} and `carryOut` = opA[0]. `sel[1:0]` and carryIn have no effect.
- R8: When `sel[3:2]` = 2'b11, `result` = {opA[WIDTH-2:0], serialIn} and `carryOut` = opA[WIDTH-1]. `sel[1:0]` and carryIn have no effect.
- R9: On a rising clock edge with `loadEn` = 1, `resultReg` takes the value `result` had before the edge. With `loadEn` = 0, `resultReg` keeps its value.
- R10: While `rstN` is low, `resultReg` is 0. The reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rstN | input | 1 | Asynchronous active-low reset of the result register |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sel | input | 4 | Operation select: [3:2] section, [1:0] variant |
| carryIn | input | 1 | Carry into the adder; used only in arithmetic operations |
| serialIn | input | 1 | Fill bit for the vacated position in shifts; tie to 0 for zero fill |
| loadEn | input | 1 | Captures `result` into `resultReg` on the next rising edge |
| result | output | WIDTH | Combinational result |
| carryOut | output | 1 | Adder carry, shifted-out bit, or 0 in logic operations |
| resultReg | output | WIDTH | Registered result |

## Verification
A wrong steering strobe appears at `result` and `carryOut` in the same cycle, with no latency. The bench therefore drives all 32 combinations of select and carry input over several operand patterns and compares each against an independent model. Errors at the edges of the adder and shifter only show for certain operand values: the wrap of increment at all ones, the decrement of zero, and a wrong fill or carry-out bit. The bench drives these values explicitly. A fault in the result register appears one edge after a load or hold decision. It is checked by loading, holding with changed inputs, and resetting.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  // Which section drives the output multiplexer
  typedef enum logic [1:0] {
    SRC_ARITH = 2'b00,
    SRC_LOGIC = 2'b01,
    SRC_SHR   = 2'b10,
    SRC_SHL   = 2'b11
  } srcSel_e;

  // What the adder sees as its second operand
  typedef enum logic [1:0] {
    Y_OPB   = 2'b00,
    Y_NOTB  = 2'b01,
    Y_ZEROS = 2'b10,
    Y_ONES  = 2'b11
  } yMode_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } logicOp_e;

  typedef struct packed {
    srcSel_e  src;
    yMode_e   yMode;
    logicOp_e logicOp;
    logic     addCarry;
  } strobes_t;

endpackage

// File: rtl/alsu_ctrl.sv
module alsu_ctrl
  import alsu_pkg::*;
(
  input  logic [3:0] sel,
  input  logic       carryIn,
  output strobes_t   strb
);

  always_comb begin
    strb.src      = srcSel_e'(sel[3:2]);
    strb.yMode    = yMode_e'(sel[1:0]);
    strb.logicOp  = logicOp_e'(sel[1:0]);
    // Carry input only reaches the adder in arithmetic operations
    strb.addCarry = carryIn & (sel[3:2] == 2'b00);
  end

endmodule

// File: rtl/alsu_dp.sv
module alsu_dp
  import alsu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             serialIn,
  input  logic             loadEn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic [WIDTH-1:0] resultReg
);

  localparam int MSB = WIDTH - 1;

  logic [MSB:0]   yOperand;
  logic [WIDTH:0] sumFull;
  logic [MSB:0]   logicOut;
  logic [MSB:0]   shrOut;
  logic [MSB:0]   shlOut;

  // Operand steering into the single adder
  always_comb begin
    unique case (strb.yMode)
      Y_OPB:   yOperand = opB;
      Y_NOTB:  yOperand = ~opB;
      Y_ZEROS: yOperand = '0;
      default: yOperand = '1;
    endcase
  end

  assign sumFull = {1'b0, opA} + {1'b0, yOperand} + {{WIDTH{1'b0}}, strb.addCarry};

  always_comb begin
    unique case (strb.logicOp)
      LG_AND:  logicOut = opA & opB;
      LG_OR:   logicOut = opA | opB;
      LG_XOR:  logicOut = opA ^ opB;
      default: logicOut = ~opA;
    endcase
  end

  // Per-bit shift taps and 4:1 output multiplexer
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign shrOut[i] = serialIn;
    end else begin : g_mid
      assign shrOut[i] = opA[i+1];
    end
    if (i == 0) begin : g_bot
      assign shlOut[i] = serialIn;
    end else begin : g_up
      assign shlOut[i] = opA[i-1];
    end
    assign result[i] = (strb.src == SRC_ARITH) ? sumFull[i] :
                       (strb.src == SRC_LOGIC) ? logicOut[i] :
                       (strb.src == SRC_SHR)   ? shrOut[i]  : shlOut[i];
  end

  always_comb begin
    unique case (strb.src)
      SRC_ARITH: carryOut = sumFull[WIDTH];
      SRC_LOGIC: carryOut = 1'b0;
      SRC_SHR:   carryOut = opA[0];
      default:   carryOut = opA[MSB];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (loadEn) begin
      resultReg <= result;
    end
  end

endmodule

// File: rtl/alsu_core.sv
module alsu_core
  import alsu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       sel,
  input  logic             carryIn,
  input  logic             serialIn,
  input  logic             loadEn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic [WIDTH-1:0] resultReg
);

  strobes_t strb;

  alsu_ctrl u_ctrl (
    .sel     (sel),
    .carryIn (carryIn),
    .strb    (strb)
  );

  alsu_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .serialIn  (serialIn),
    .loadEn    (loadEn),
    .result    (result),
    .carryOut  (carryOut),
    .resultReg (resultReg)
  );

endmodule

// File: rtl/alsu_chk.sv
module alsu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       sel,
  input logic             carryIn,
  input logic             serialIn,
  input logic             loadEn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic [WIDTH-1:0] resultReg
);

  localparam int MSB = WIDTH - 1;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(resultReg));

  // R9
  load_captures_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> resultReg == $past(result));

  // R6
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel[3:2] == 2'b01 |-> carryOut == 1'b0);

  // R7
  shift_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel[3:2] == 2'b10 |-> (carryOut == opA[0]) && (result == {serialIn, opA[MSB:1]}));

  // R8
  shift_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel[3:2] == 2'b11 |-> (carryOut == opA[MSB]) && (result == {opA[MSB-1:0], serialIn}));

  // R3
  pass_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 4'b0010 && !carryIn) |-> (result == opA) && !carryOut);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rstN) |-> resultReg == '0);

endmodule

bind alsu_core alsu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alsu_core_tb.sv
module alsu_core_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   sel = '0;
  logic         carryIn = 1'b0;
  logic         serialIn = 1'b0;
  logic         loadEn = 1'b0;
  logic [W-1:0] result;
  logic         carryOut;
  logic [W-1:0] resultReg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alsu_core #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .sel(sel),
    .carryIn(carryIn), .serialIn(serialIn), .loadEn(loadEn),
    .result(result), .carryOut(carryOut), .resultReg(resultReg)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
               tag, sel, carryIn, opA, opB, act, exp);
    end
  endtask

  // Model written from the requirements: returns {carry, result}
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [3:0] s, input logic cin, input logic si);
    logic [W-1:0] y;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: y = b;
          2'b01: y = ~b;
          2'b10: y = '0;
          default: y = '1;
        endcase
        return {1'b0, a} + {1'b0, y} + (W+1)'(cin);
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, a & b};
          2'b01: return {1'b0, a | b};
          2'b10: return {1'b0, a ^ b};
          default: return {1'b0, ~a};
        endcase
      end
      2'b10: return {a[0], si, a[W-1:1]};
      default: return {a[W-1], a[W-2:0], si};
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] s);
    case (s[3:2])
      2'b00: case (s[1:0])
               2'b00: return "R1";
               2'b01: return "R2";
               2'b10: return "R3";
               default: return "R4";
             endcase
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic applyAndCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [3:0] s, input logic cin, input logic si);
    logic [W:0] exp;
    @(negedge clk);
    opA = a; opB = b; sel = s; carryIn = cin; serialIn = si;
    #1;
    exp = model(a, b, s, cin, si);
    check(tagOf(s), 64'(result), 64'(exp[W-1:0]));
    check(s[3:2] == 2'b00 ? "R5" : tagOf(s), 64'(carryOut), 64'(exp[W]));
  endtask

  task automatic testResetState();
    #1;
    check("R10", 64'(resultReg), 64'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testSweepAll();
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 8; k++) begin
          logic [W-1:0] a;
          logic [W-1:0] b;
          a = W'($urandom);
          b = W'($urandom);
          if (k == 0) begin a = '0; b = '1; end
          if (k == 1) begin a = '1; b = W'(1); end
          if (k == 2) begin a = {1'b1, {(W-1){1'b0}}}; b = a; end
          applyAndCheck(a, b, 4'(s), 1'(c), 1'($urandom));
        end
      end
    end
  endtask

  task automatic testArithEdges();
    // R3 increment wraps at all ones with carry out
    applyAndCheck('1, W'(16'h1234), 4'b0010, 1'b1, 1'b0);
    check("R3", 64'(result), 64'h0);
    check("R5", 64'(carryOut), 64'h1);
    // R4 decrement of zero gives all ones, no carry
    applyAndCheck('0, W'(16'h00ff), 4'b0011, 1'b0, 1'b0);
    check("R4", 64'(result), 64'(W'('1)));
    check("R5", 64'(carryOut), 64'h0);
    // R2 0 - 1 = all ones, borrow shown as carry 0
    applyAndCheck('0, W'(1), 4'b0001, 1'b1, 1'b0);
    check("R2", 64'(result), 64'(W'('1)));
    check("R5", 64'(carryOut), 64'h0);
    // R1 all ones plus one overflows
    applyAndCheck('1, W'(1), 4'b0000, 1'b0, 1'b0);
    check("R1", 64'(result), 64'h0);
    check("R5", 64'(carryOut), 64'h1);
  endtask

  task automatic testLogicIgnoresCarry();
    applyAndCheck(W'(16'hf0f0), W'(16'hff00), 4'b0110, 1'b1, 1'b0);
    check("R6", 64'(result), 64'(W'(16'h0ff0)));
    check("R6", 64'(carryOut), 64'h0);
    applyAndCheck(W'(16'h00ff), W'(16'h0000), 4'b0111, 1'b1, 1'b1);
    check("R6", 64'(result), 64'(W'(16'hff00)));
  endtask

  task automatic testShiftFill();
    applyAndCheck(W'(16'h8001), W'(16'h5555), 4'b1011, 1'b1, 1'b1);
    check("R7", 64'(result), 64'(W'(16'hc000)));
    check("R7", 64'(carryOut), 64'h1);
    applyAndCheck(W'(16'h8001), W'(16'h5555), 4'b1100, 1'b0, 1'b0);
    check("R8", 64'(result), 64'(W'(16'h0002)));
    check("R8", 64'(carryOut), 64'h1);
    applyAndCheck(W'(16'h4000), W'(16'h0), 4'b1110, 1'b1, 1'b1);
    check("R8", 64'(result), 64'(W'(16'h8001)));
    check("R8", 64'(carryOut), 64'h0);
  endtask

  task automatic testLoadHold();
    @(negedge clk);
    opA = W'(16'h1111); opB = W'(16'h2222); sel = 4'b0000; carryIn = 1'b0; loadEn = 1'b1;
    @(posedge clk); #1;
    check("R9", 64'(resultReg), 64'(W'(16'h3333)));
    loadEn = 1'b0;
    @(negedge clk);
    opA = W'(16'habcd); sel = 4'b0111;
    @(posedge clk); #1;
    check("R9", 64'(resultReg), 64'(W'(16'h3333)));
    @(negedge clk);
    loadEn = 1'b1;
    @(posedge clk); #1;
    check("R9", 64'(resultReg), 64'(W'(16'h5432)));
    loadEn = 1'b0;
  endtask

  task automatic testResetClears();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R10", 64'(resultReg), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R10", 64'(resultReg), 64'h0);
  endtask

  initial begin
    testResetState();
    testSweepAll();
    testArithEdges();
    testLogicIgnoresCarry();
    testShiftFill();
    testLoadHold();
    testResetClears();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before tests completed");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule